// File: doc/BRIEF.md
# Scaled-Index Address Generation Unit

This unit forms a memory operand's effective address from up to three terms: an optional base register value, an optional index register value multiplied by 1, 2, 4 or 8, and a signed displacement of one, two or four bytes. A request names the two source registers by number. The unit presents those numbers on two combinational read ports into a 16-entry register file. It adds the terms and registers the 64-bit sum together with a flag that marks a malformed request.

The request is sampled on a clock edge while the valid strobe is high. The result and its own valid strobe appear on the next edge. Requests may arrive back to back, one per cycle. Two encodings are rejected. The first is register 4, the stack pointer, used as an index while the index is enabled. The second is the reserved displacement size code. A rejected request still produces a result beat, with the flag set and the address forced to zero.

Top module: `ea_calc_unit`

## Requirements
- R1: On an accepted request the result address equals base term + scaled index term + extended displacement, and the sum wraps modulo 2^64.
- R2: Scale code 0, 1, 2 and 3 multiply the index value by 1, 2, 4 and 8 respectively.
- R3: Displacement size code 0 takes `disp[7:0]`, code 1 takes `disp[15:0]` and code 2 takes `disp[31:0]`. Each is sign-extended to 64 bits. Displacement bits above the selected size have no effect on the result.
- R4: With `base_en` low the base term is zero, whatever value the base read port returns.
- R5: With `index_en` low the index term is zero, and `index_sel` (including 4) raises no fault.
- R6: With `index_en` high and `index_sel` equal to 4, the result beat has `out_illegal` high and `out_addr` zero. Register 4 remains legal as a base.
- R7: Displacement size code 3 is reserved. A request using it gives `out_illegal` high and `out_addr` zero.
- R8: `out_valid` is high exactly in the cycle after each cycle in which `in_valid` was sampled high, so back-to-back requests give back-to-back results.
- R9: While `in_valid` is low, `out_addr` and `out_illegal` keep their last values and `out_valid` is low.
- R10: After synchronous reset, `out_valid`, `out_illegal` and `out_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| base_en | input | 1 | Base term present |
| base_sel | input | 4 | Base register number |
| index_en | input | 1 | Index term present |
| index_sel | input | 4 | Index register number |
| scale_code | input | 2 | Index multiplier code (0..3 gives 1, 2, 4, 8) |
| disp_size | input | 2 | Displacement width code (0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes, 3 is reserved) |
| disp | input | 32 | Raw displacement, low bits used per size code |
| base_rsel | output | 4 | Register read port A address (base) |
| index_rsel | output | 4 | Register read port B address (index) |
| base_rdata | input | 64 | Register read port A data |
| index_rdata | input | 64 | Register read port B data |
| out_valid | output | 1 | Result strobe |
| out_addr | output | 64 | Effective address |
| out_illegal | output | 1 | Malformed request flag |

## Verification
The assertions assume the register file answers combinationally within the same cycle. They also assume the request fields are stable from one falling edge to the next, so the value sampled at the rising edge is the value the request meant. The stimulus changes every request field and register-file entry only at falling edges. The random mix draws all four scale codes and all four size codes, and lets the index number land on the stack pointer often enough to exercise both reject paths and the result hold on idle cycles.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [1:0] {
        SCL_X1 = 2'd0,
        SCL_X2 = 2'd1,
        SCL_X4 = 2'd2,
        SCL_X8 = 2'd3
    } scale_e;

    typedef enum logic [1:0] {
        DSZ_B1   = 2'd0,
        DSZ_B2   = 2'd1,
        DSZ_B4   = 2'd2,
        DSZ_RSVD = 2'd3
    } dsize_e;

    typedef struct packed {
        logic bad_index;
        logic bad_dsize;
    } fault_t;

    function automatic logic dsize_ok(dsize_e sz);
        return sz != DSZ_RSVD;
    endfunction

endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext
    import ea_pkg::*;
#(
    parameter int unsigned DISP_W = 32,
    parameter int unsigned ADDR_W = 64
) (
    input  logic [DISP_W-1:0] disp,
    input  dsize_e            size,
    output logic [ADDR_W-1:0] ext
);
    localparam int unsigned W1 = 8;
    localparam int unsigned W2 = 16;
    localparam int unsigned W4 = 32;

    always_comb begin
        unique case (size)
            DSZ_B1:  ext = {{(ADDR_W-W1){disp[W1-1]}}, disp[W1-1:0]};
            DSZ_B2:  ext = {{(ADDR_W-W2){disp[W2-1]}}, disp[W2-1:0]};
            DSZ_B4:  ext = {{(ADDR_W-W4){disp[W4-1]}}, disp[W4-1:0]};
            default: ext = '0;
        endcase
    end
endmodule

// File: rtl/ea_scaler.sv
module ea_scaler
    import ea_pkg::*;
#(
    parameter int unsigned ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] value,
    input  logic              enable,
    input  scale_e            scale,
    output logic [ADDR_W-1:0] term
);
    localparam int unsigned N_SCALE = 4;

    logic [ADDR_W-1:0] shifted [N_SCALE];

    for (genvar k = 0; k < N_SCALE; k++) begin : g_shift
        assign shifted[k] = value << k;
    end

    assign term = enable ? shifted[2'(scale)] : '0;
endmodule

// File: rtl/ea_legal_chk.sv
module ea_legal_chk
    import ea_pkg::*;
#(
    parameter int unsigned RSEL_W = 4,
    parameter int unsigned SP_SEL = 4
) (
    input  logic              index_en,
    input  logic [RSEL_W-1:0] index_sel,
    input  dsize_e            size,
    output fault_t            fault
);
    always_comb begin
        fault.bad_index = index_en && (index_sel == RSEL_W'(SP_SEL));
        fault.bad_dsize = !dsize_ok(size);
    end
endmodule

// File: rtl/ea_calc_unit.sv
module ea_calc_unit
    import ea_pkg::*;
#(
    parameter int unsigned ADDR_W  = 64,
    parameter int unsigned DISP_W  = 32,
    parameter int unsigned REG_CNT = 16,
    parameter int unsigned SP_SEL  = 4,
    localparam int unsigned RSEL_W = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              base_en,
    input  logic [RSEL_W-1:0] base_sel,
    input  logic              index_en,
    input  logic [RSEL_W-1:0] index_sel,
    input  logic [1:0]        scale_code,
    input  logic [1:0]        disp_size,
    input  logic [DISP_W-1:0] disp,
    output logic [RSEL_W-1:0] base_rsel,
    output logic [RSEL_W-1:0] index_rsel,
    input  logic [ADDR_W-1:0] base_rdata,
    input  logic [ADDR_W-1:0] index_rdata,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_illegal
);
    logic [ADDR_W-1:0] base_term;
    logic [ADDR_W-1:0] index_term;
    logic [ADDR_W-1:0] disp_term;
    logic [ADDR_W-1:0] sum;
    fault_t            fault;
    logic              reject;

    assign base_rsel  = base_sel;
    assign index_rsel = index_sel;
    assign base_term  = base_en ? base_rdata : '0;

    ea_scaler #(.ADDR_W(ADDR_W)) u_scaler (
        .value  (index_rdata),
        .enable (index_en),
        .scale  (scale_e'(scale_code)),
        .term   (index_term)
    );

    ea_disp_ext #(.DISP_W(DISP_W), .ADDR_W(ADDR_W)) u_disp (
        .disp (disp),
        .size (dsize_e'(disp_size)),
        .ext  (disp_term)
    );

    ea_legal_chk #(.RSEL_W(RSEL_W), .SP_SEL(SP_SEL)) u_legal (
        .index_en  (index_en),
        .index_sel (index_sel),
        .size      (dsize_e'(disp_size)),
        .fault     (fault)
    );

    assign sum    = base_term + index_term + disp_term;
    assign reject = |fault;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_addr    <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_illegal <= reject;
                out_addr    <= reject ? '0 : sum;
            end
        end
    end
endmodule

// File: rtl/ea_calc_checker.sv
module ea_calc_checker #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned DISP_W = 32,
    parameter int unsigned RSEL_W = 4,
    parameter int unsigned SP_SEL = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              base_en,
    input logic              index_en,
    input logic [RSEL_W-1:0] index_sel,
    input logic [1:0]        disp_size,
    input logic [DISP_W-1:0] disp,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_illegal
);
    assert_result_follows_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_addr) && $stable(out_illegal)));

    assert_sp_index_rejected_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && index_en && index_sel == RSEL_W'(SP_SEL)) |=> (out_illegal && out_addr == '0));

    assert_rsvd_size_rejected_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && disp_size == 2'd3) |=> (out_illegal && out_addr == '0));

    assert_disp_only_byte_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !base_en && !index_en && disp_size == 2'd0)
        |=> (!out_illegal && out_addr == {{(ADDR_W-8){$past(disp[7])}}, $past(disp[7:0])}));
endmodule

bind ea_calc_unit ea_calc_checker #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .RSEL_W (RSEL_W),
    .SP_SEL (SP_SEL)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .base_en     (base_en),
    .index_en    (index_en),
    .index_sel   (index_sel),
    .disp_size   (disp_size),
    .disp        (disp),
    .out_valid   (out_valid),
    .out_addr    (out_addr),
    .out_illegal (out_illegal)
);

// File: tb/ea_calc_unit_test.sv
`timescale 1ns/1ps
module ea_calc_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        base_en;
    logic [3:0]  base_sel;
    logic        index_en;
    logic [3:0]  index_sel;
    logic [1:0]  scale_code;
    logic [1:0]  disp_size;
    logic [31:0] disp;
    logic [3:0]  base_rsel;
    logic [3:0]  index_rsel;
    logic [63:0] base_rdata;
    logic [63:0] index_rdata;
    logic        out_valid;
    logic [63:0] out_addr;
    logic        out_illegal;

    logic [63:0] rf [16];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign base_rdata  = rf[base_rsel];
    assign index_rdata = rf[index_rsel];

    ea_calc_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .base_en(base_en), .base_sel(base_sel),
        .index_en(index_en), .index_sel(index_sel),
        .scale_code(scale_code), .disp_size(disp_size), .disp(disp),
        .base_rsel(base_rsel), .index_rsel(index_rsel),
        .base_rdata(base_rdata), .index_rdata(index_rdata),
        .out_valid(out_valid), .out_addr(out_addr), .out_illegal(out_illegal)
    );

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    function automatic void model(input logic be, input logic [3:0] bs,
                                  input logic ie, input logic [3:0] is,
                                  input logic [1:0] sc, input logic [1:0] dz,
                                  input logic [31:0] d,
                                  output logic [63:0] a, output logic il);
        longint signed dv;
        logic [63:0] bv, iv;
        case (dz)
            2'd0: dv = longint'($signed(d[7:0]));
            2'd1: dv = longint'($signed(d[15:0]));
            2'd2: dv = longint'($signed(d[31:0]));
            default: dv = 0;
        endcase
        bv = be ? rf[bs] : 64'd0;
        iv = ie ? rf[is] * (64'd1 << sc) : 64'd0;
        il = (ie && is == 4'd4) || (dz == 2'd3);
        a  = il ? 64'd0 : bv + iv + 64'(dv);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called just after a falling edge; leaves in_valid high.
    task automatic issue(input string req, input logic be, input logic [3:0] bs,
                         input logic ie, input logic [3:0] is,
                         input logic [1:0] sc, input logic [1:0] dz,
                         input logic [31:0] d);
        logic [63:0] ea;
        logic        eil;
        base_en = be; base_sel = bs; index_en = ie; index_sel = is;
        scale_code = sc; disp_size = dz; disp = d; in_valid = 1'b1;
        model(be, bs, ie, is, sc, dz, d, ea, eil);
        @(negedge clk);
        check(req, "valid (R8)", 64'(out_valid), 64'd1);
        check(req, "addr", out_addr, ea);
        check(req, "illegal", 64'(out_illegal), 64'(eil));
    endtask

    task automatic idle();
        logic [63:0] pa;
        logic        pi;
        pa = out_addr; pi = out_illegal;
        in_valid = 1'b0;
        base_en = 1'($urandom()); base_sel = 4'($urandom());
        index_en = 1'($urandom()); index_sel = 4'($urandom());
        disp = $urandom(); disp_size = 2'($urandom()); scale_code = 2'($urandom());
        @(negedge clk);
        check("R9", "valid low", 64'(out_valid), 64'd0);
        check("R9", "addr held", out_addr, pa);
        check("R9", "illegal held", 64'(out_illegal), 64'(pi));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) rf[i] = rnd64();
        rst = 1'b1; in_valid = 1'b0; base_en = 1'b0; base_sel = '0;
        index_en = 1'b0; index_sel = '0; scale_code = '0; disp_size = '0; disp = '0;
        repeat (3) @(negedge clk);
        check("R10", "valid", 64'(out_valid), 64'd0);
        check("R10", "addr", out_addr, 64'd0);
        check("R10", "illegal", 64'(out_illegal), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        rf[2] = 64'h0000_0000_0000_f000;
        rf[1] = 64'h0000_0000_0000_0100;
        // R1 worked values
        issue("R1 base+disp8",      1, 4'd2, 0, 4'd0, 2'd0, 2'd0, 32'h0000_0008);
        check("R1", "0xf008", out_addr, 64'hf008);
        issue("R2 scale1",          1, 4'd2, 1, 4'd1, 2'd0, 2'd0, 32'h0);
        check("R2", "0xf100", out_addr, 64'hf100);
        issue("R2 scale4",          1, 4'd2, 1, 4'd1, 2'd2, 2'd0, 32'h0);
        check("R2", "0xf400", out_addr, 64'hf400);
        issue("R4 no base scale2",  0, 4'd1, 1, 4'd2, 2'd1, 2'd1, 32'h0000_0080);
        check("R4", "0x1e080", out_addr, 64'h1e080);
        issue("R2 scale8",          0, 4'd0, 1, 4'd1, 2'd3, 2'd0, 32'h0);
        check("R2", "0x800", out_addr, 64'h800);
        // R3 sign extension and ignored upper bits
        issue("R3 byte neg",        1, 4'd2, 0, 4'd0, 2'd0, 2'd0, 32'hABCD_12FF);
        check("R3", "base-1", out_addr, 64'hefff);
        issue("R3 half neg",        0, 4'd0, 0, 4'd0, 2'd0, 2'd1, 32'h1234_8000);
        check("R3", "sext16", out_addr, 64'hffff_ffff_ffff_8000);
        issue("R3 word neg",        0, 4'd0, 0, 4'd0, 2'd0, 2'd2, 32'h8000_0000);
        check("R3", "sext32", out_addr, 64'hffff_ffff_8000_0000);
        // R1 wraparound
        rf[7] = 64'hffff_ffff_ffff_ffff;
        issue("R1 wrap",            1, 4'd7, 0, 4'd0, 2'd0, 2'd0, 32'h1);
        check("R1", "wrap to 0", out_addr, 64'd0);
        // R6 / R5 stack pointer handling
        rf[4] = 64'h0000_0000_0000_1000;
        issue("R6 sp index",        1, 4'd2, 1, 4'd4, 2'd0, 2'd0, 32'h4);
        check("R6", "flag", 64'(out_illegal), 64'd1);
        issue("R6 sp base legal",   1, 4'd4, 1, 4'd1, 2'd0, 2'd0, 32'h0);
        check("R6", "sp base", out_addr, 64'h1100);
        issue("R5 sp index off",    1, 4'd2, 0, 4'd4, 2'd3, 2'd0, 32'h0);
        check("R5", "no fault", 64'(out_illegal), 64'd0);
        check("R5", "no index term", out_addr, 64'hf000);
        // R7 reserved size
        issue("R7 rsvd size",       1, 4'd2, 0, 4'd0, 2'd0, 2'd3, 32'h10);
        check("R7", "addr zero", out_addr, 64'd0);
        idle();
        idle();

        // Constrained random, back-to-back with occasional idles
        for (int n = 0; n < 400; n++) begin
            if (n % 37 == 0) rf[4'($urandom())] = rnd64();
            if ($urandom_range(0, 5) == 0) idle();
            issue("R1 random", 1'($urandom()), 4'($urandom()), 1'($urandom()),
                  ($urandom_range(0, 7) == 0) ? 4'd4 : 4'($urandom()),
                  2'($urandom()),
                  ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2)),
                  $urandom());
        end
        idle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule